// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a 10-bit successive-approximation converter. It holds the channel, mode and start-source settings. It drives the analog multiplexer select and the trial code for the DAC, and reads back a single comparator bit. It builds the result one bit per conversion-clock enable, starting with the most significant bit. A conversion starts in one of two ways: a register write with the start bit set, or a rising edge on an external trigger pin once that source has been chosen. Each conversion has a sample phase, timed by a sample-clock enable, followed by ten bit decisions, timed by a separate conversion-clock enable. Both enables come from internal prescalers that restart on every phase change, so the length of a conversion is fixed.

In single mode one conversion runs for each start. In continuous mode the next sample phase begins in the same cycle that the result is loaded, and conversions repeat until software clears the mode bit. Clearing the bit lets the conversion in progress finish before the sequencer stops. Every completed conversion sets an interrupt flag. The flag stays set until software clears it with a write.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy, irq, result, mux_sel and dac_code are all zero.
- R2: The 10-bit result is found MSB first. For each bit from 9 down to 0, the bit is set as a trial and kept only when cmp_in is 1, meaning the input is at or above dac_code. With an ideal comparator the result equals the input level.
- R3: A write with wr_en places wr_chan (0 to 14) on mux_sel. Code 15 is ignored and the previous channel is kept. While busy, channel and start-source writes are ignored, so mux_sel holds steady through a conversion.
- R4: busy rises on the clock edge that accepts a software start. It stays high for SAMPLE_TICKS*SAMPLE_DIV + RES_W*CONV_DIV cycles, which is 56 cycles at the default parameters.
- R5: A write with wr_start=1 and wr_ext=0 starts a conversion. Such a write has no effect while busy. A write with wr_start=1 and wr_ext=1 starts nothing.
- R6: When the external source is selected (wr_ext=1 stored), a rising edge on ext_trig makes busy rise on the third rising clock edge after the pin goes high. A trigger edge that arrives while busy is ignored, and no start is held for later.
- R7: irq is set in the cycle each result is loaded and stays set until a write with wr_irq_clr=1. If a completion and a clear fall in the same cycle, the completion wins.
- R8: In single mode (wr_cont=0) one conversion runs per start, and busy then stays low.
- R9: In continuous mode (wr_cont=1) busy stays high across result loads. A new sample phase begins at once, and result updates with every completed conversion.
- R10: Writing wr_cont=0 during a continuous run lets the current conversion complete and load its result. busy then falls and stays low.
- R11: dac_code carries the trial code during the bit phase. The first trial after sampling is 0x200. While idle, dac_code holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_chan | input | 4 | Channel code to store (0 to 14) |
| wr_cont | input | 1 | 1 = continuous mode, 0 = single mode |
| wr_ext | input | 1 | 1 = external trigger is the start source |
| wr_start | input | 1 | Software start request |
| wr_irq_clr | input | 1 | Clear the interrupt flag |
| ext_trig | input | 1 | External start-of-conversion trigger (asynchronous) |
| cmp_in | input | 1 | Comparator: 1 when input >= DAC level |
| mux_sel | output | 4 | Analog channel select |
| dac_code | output | 10 | Trial code for the DAC |
| result | output | 10 | Last completed conversion result |
| busy | output | 1 | Sample or bit phase in progress |
| irq | output | 1 | Conversion-complete interrupt flag |

## Verification
A wrong bit decision or a wrong trial pointer in the approximation register shows on dac_code within one conversion-clock period. It reaches result, and therefore irq, at the end of that same conversion. A fault in the prescaler or in the phase sequencing changes the number of cycles busy stays high, and that count is compared exactly against the parameter formula. Faults in mode or start-source handling show as busy rising when it must not, or staying high, and they appear within one conversion length of the stimulus.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_tick_gen.sv
// Divides the clock into a one-cycle enable every DIV cycles; restarts on clr.
module sar_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_trig_sync.sv
// Two-stage synchroniser plus a third stage for rising-edge detection.
module sar_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], trig_in};
  end

  assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/sar_ctrl.sv
// Phase sequencer and successive-approximation register.
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_W        = 10,
  parameter int unsigned SAMPLE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont,
  input  logic             samp_tick,
  input  logic             conv_tick,
  input  logic             cmp_in,
  output logic             busy,
  output logic             div_clr,
  output logic             done,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);
  localparam int unsigned SC_W = $clog2(SAMPLE_TICKS + 1);
  localparam int unsigned BI_W = $clog2(RES_W);

  sar_state_e       state_q, state_d;
  logic [SC_W-1:0]  scnt_q, scnt_d;
  logic [BI_W-1:0]  bit_q, bit_d;
  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    state_d = state_q;
    scnt_d  = scnt_q;
    bit_d   = bit_q;
    sar_d   = sar_q;
    res_d   = res_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SAMPLE;
          scnt_d  = '0;
        end
      end
      ST_SAMPLE: begin
        if (samp_tick) begin
          if (scnt_q == SC_W'(SAMPLE_TICKS - 1)) begin
            state_d            = ST_CONV;
            bit_d              = BI_W'(RES_W - 1);
            sar_d              = '0;
            sar_d[RES_W-1]     = 1'b1;
          end else begin
            scnt_d = scnt_q + 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (conv_tick) begin
          sar_d[bit_q] = cmp_in;
          if (bit_q == '0) begin
            res_d = sar_d;
            done  = 1'b1;
            if (cont) begin
              state_d = ST_SAMPLE;
              scnt_d  = '0;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            sar_d[bit_q - 1'b1] = 1'b1;
            bit_d               = bit_q - 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Prescalers restart on every phase change, including a continuous restart.
  assign div_clr = (state_d != state_q) || done;
  assign busy    = (state_q != ST_IDLE);
  assign trial   = sar_q;
  assign result  = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scnt_q  <= '0;
      bit_q   <= '0;
      sar_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      scnt_q  <= scnt_d;
      bit_q   <= bit_d;
      sar_q   <= sar_d;
      res_q   <= res_d;
    end
  end
endmodule

// File: rtl/sar_seq.sv
// Top: control register, start arbitration, interrupt flag.
module sar_seq #(
  parameter int unsigned RES_W        = 10,
  parameter int unsigned NUM_CH       = 15,
  parameter int unsigned SAMPLE_DIV   = 8,
  parameter int unsigned CONV_DIV     = 4,
  parameter int unsigned SAMPLE_TICKS = 2,
  localparam int unsigned CH_W        = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic             wr_cont,
  input  logic             wr_ext,
  input  logic             wr_start,
  input  logic             wr_irq_clr,
  input  logic             ext_trig,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             busy,
  output logic             irq
);
  logic [CH_W-1:0] chan_q, chan_d;
  logic            cont_q, cont_d;
  logic            ext_q, ext_d;
  logic            irq_q, irq_d;
  logic            trig_rise, samp_tick, conv_tick, div_clr, done, start;

  sar_trig_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (ext_trig),
    .rise    (trig_rise)
  );

  sar_tick_gen #(.DIV(SAMPLE_DIV)) u_samp_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (div_clr),
    .tick  (samp_tick)
  );

  sar_tick_gen #(.DIV(CONV_DIV)) u_conv_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (div_clr),
    .tick  (conv_tick)
  );

  sar_ctrl #(
    .RES_W        (RES_W),
    .SAMPLE_TICKS (SAMPLE_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cont      (cont_q),
    .samp_tick (samp_tick),
    .conv_tick (conv_tick),
    .cmp_in    (cmp_in),
    .busy      (busy),
    .div_clr   (div_clr),
    .done      (done),
    .trial     (dac_code),
    .result    (result)
  );

  assign start = ~busy & ((wr_en & wr_start & ~wr_ext) | (ext_q & trig_rise));

  always_comb begin
    chan_d = chan_q;
    ext_d  = ext_q;
    cont_d = cont_q;
    irq_d  = irq_q;
    if (wr_en) begin
      cont_d = wr_cont;
      if (!busy) begin
        ext_d = wr_ext;
        if (wr_chan < CH_W'(NUM_CH)) chan_d = wr_chan;
      end
      if (wr_irq_clr) irq_d = 1'b0;
    end
    if (done) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      cont_q <= 1'b0;
      ext_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      chan_q <= chan_d;
      cont_q <= cont_d;
      ext_q  <= ext_d;
      irq_q  <= irq_d;
    end
  end

  assign mux_sel = chan_q;
  assign irq     = irq_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned NUM_CH = 15,
  parameter int unsigned CH_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CH_W-1:0]  mux_sel,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic             busy,
  input logic             irq
);
  // R7
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R3
  mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel));

  // R3
  chan_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_sel < CH_W'(NUM_CH));

  // R7
  result_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> irq);

  // R11
  dac_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(dac_code));
endmodule

bind sar_seq sar_seq_chk #(
  .RES_W  (RES_W),
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mux_sel  (mux_sel),
  .dac_code (dac_code),
  .result   (result),
  .busy     (busy),
  .irq      (irq)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  logic       clk;
  logic       rst_n;
  logic       wr_en, wr_cont, wr_ext, wr_start, wr_irq_clr;
  logic [3:0] wr_chan;
  logic       ext_trig;
  logic       cmp_in;
  logic [3:0] mux_sel;
  logic [9:0] dac_code, result;
  logic       busy, irq;
  logic [9:0] vin [16];

  int checks = 0;
  int errors = 0;

  sar_seq u_sar_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .wr_cont    (wr_cont),
    .wr_ext     (wr_ext),
    .wr_start   (wr_start),
    .wr_irq_clr (wr_irq_clr),
    .ext_trig   (ext_trig),
    .cmp_in     (cmp_in),
    .mux_sel    (mux_sel),
    .dac_code   (dac_code),
    .result     (result),
    .busy       (busy),
    .irq        (irq)
  );

  // Ideal analog model: selected input level against the DAC code.
  assign cmp_in = (vin[mux_sel] >= dac_code);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input bit c, input bit e, input bit s, input bit k);
    wr_chan = 4'(ch); wr_cont = c; wr_ext = e; wr_start = s; wr_irq_clr = k;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_start = 1'b0; wr_irq_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 300 && !irq; i++) @(negedge clk);
  endtask

  task automatic stays_idle(input string req);
    int hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy) hi++;
    end
    chk(req, hi, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 result", result, 0);
    chk("R1 mux_sel", mux_sel, 0);
    chk("R1 dac_code", dac_code, 0);
  endtask

  task automatic t_chan();
    wr(5, 0, 0, 0, 0);
    chk("R3 channel 5", mux_sel, 5);
    wr(15, 0, 0, 0, 0);
    chk("R3 code 15 ignored", mux_sel, 5);
    wr(14, 0, 1, 1, 0);
    chk("R3 channel 14", mux_sel, 14);
    chk("R5 start with ext source", busy, 0);
    stays_idle("R5 no start when ext");
  endtask

  task automatic t_single_timing();
    int n;
    vin[3] = 10'h2A5;
    wr(3, 0, 0, 1, 0);
    chk("R4 busy on accept", busy, 1);
    n = 1;
    wr_chan = 4'd7; wr_start = 1'b1; wr_ext = 1'b0; wr_cont = 1'b0;
    for (int i = 0; i < 200 && busy; i++) begin
      wr_en = (n == 30);
      @(negedge clk);
      if (busy) begin
        n++;
        if (n == 17) chk("R11 first trial", dac_code, 10'h200);
      end
    end
    wr_en = 1'b0; wr_start = 1'b0;
    chk("R4 busy length", n, 56);
    chk("R5 start while busy ignored (R3 mux held)", mux_sel, 3);
    chk("R2 result", result, 10'h2A5);
    chk("R7 irq set", irq, 1);
    stays_idle("R8 single mode stops");
    wr(3, 0, 0, 0, 1);
    chk("R7 irq cleared", irq, 0);
  endtask

  task automatic t_patterns();
    int lv [6] = '{0, 1023, 512, 511, 1, 341};
    for (int p = 0; p < 6; p++) begin
      vin[p + 8] = 10'(lv[p]);
      vin[p]     = 10'(1023 - lv[p]);
      wr(p + 8, 0, 0, 1, 1);
      wait_idle();
      chk("R2 pattern", result, lv[p]);
      chk("R7 irq per conversion", irq, 1);
    end
    wr(0, 0, 0, 0, 1);
  endtask

  task automatic t_ext();
    vin[9] = 10'h3C3;
    wr(9, 0, 1, 0, 0);
    chk("R6 no start on select", busy, 0);
    ext_trig = 1'b1;
    @(negedge clk);
    chk("R6 edge 1", busy, 0);
    @(negedge clk);
    chk("R6 edge 2", busy, 0);
    @(negedge clk);
    chk("R6 edge 3", busy, 1);
    repeat (8) @(negedge clk);
    ext_trig = 1'b0;
    repeat (4) @(negedge clk);
    ext_trig = 1'b1;
    wait_idle();
    chk("R6 ext result", result, 10'h3C3);
    stays_idle("R6 trigger while busy ignored");
    ext_trig = 1'b0;
    wr(9, 0, 0, 0, 1);
  endtask

  task automatic t_cont();
    vin[2] = 10'h0F0;
    wr(2, 1, 0, 1, 1);
    wait_irq();
    chk("R9 first result", result, 10'h0F0);
    chk("R9 busy across load", busy, 1);
    vin[2] = 10'h30F;
    wr(2, 1, 0, 0, 1);
    chk("R7 irq clear while running", irq, 0);
    wait_irq();
    chk("R9 second result", result, 10'h30F);
    chk("R9 still busy", busy, 1);
    vin[2] = 10'h0AA;
    wr(2, 0, 0, 0, 1);
    chk("R10 running after stop write", busy, 1);
    wait_idle();
    chk("R10 last result", result, 10'h0AA);
    chk("R10 irq on last", irq, 1);
    stays_idle("R10 stopped");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) vin[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_chan = '0; wr_cont = 1'b0; wr_ext = 1'b0;
    wr_start = 1'b0; wr_irq_clr = 1'b0; ext_trig = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chan();
    t_single_timing();
    t_patterns();
    t_ext();
    t_cont();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule